// File: doc/BRIEF.md
# Mailbox Virtual Register Engine

This block is the device side of a host-to-controller mailbox. A host reaches it through a 10-byte I/O window. To issue a command, the host first sets a 16-bit mailbox pointer. It then fills the mailbox with a request: an access type, an entry count, a 16-bit virtual register address and, for a write, a data byte. Finally it rings a doorbell.

After a programmable delay, the engine carries out one byte read or one byte write on an internal virtual register file. It reports completion through a write-one-to-clear interrupt source bit and a status byte. For a read, the result byte is placed in the mailbox's first data location, where the host fetches it.

The virtual register file is a single-port byte memory written so that block RAM can be inferred. Access to the mailbox is positioned by the pointer: each of the four data offsets of the window reaches the location at the pointer's low byte plus that offset's position.

Top module: `vreg_mailbox`

## Requirements
- R1: After reset every window offset 0 through 9 reads 0x00. A read is returned on `host_rdata` after the clock edge at which `host_rd` is sampled high.
- R2: Offsets 2 and 3 hold the pointer's low and high byte and read back as written. Offsets 4 to 7 reach mailbox location (pointer low byte + offset - 4) only when the pointer high byte is 0x80 and that location is below MBOX_BYTES (default 8). Otherwise writes there are dropped and reads return 0x00.
- R3: Writing 0x01 to offset 0 while idle starts a command. Offset 0 then reads 0x01 until completion and 0x00 afterwards. Any other value written to offset 0, and any doorbell written while a command runs, has no effect.
- R4: At the doorbell the engine latches the request fields from the mailbox: access type from location 0, entry count from location 1, data from location 4, and address low and high bytes from locations 6 and 7. Later mailbox writes do not change a running command.
- R5: Bit 0 of offset 8 (completion) and the status byte at offset 1 take their new values exactly LATENCY clock cycles (default 8, minimum 3) after the doorbell edge.
- R6: Access type 0x03 with entry count 0x01 and an address below VREG_DEPTH (default 2048) stores the data byte at that address and completes with status 0x01.
- R7: Access type 0x02 with entry count 0x01 places the stored byte in mailbox location 4 and completes with status 0x01.
- R8: For an address at or above VREG_DEPTH, a read returns 0x00 and a write is dropped. Both complete with status 0x01.
- R9: An access type other than 0x02 or 0x03, or an entry count other than 0x01, completes with status 0xFF. It leaves both the register file and mailbox location 4 unchanged.
- R10: Writing a 1 in bit 0 of offset 8 clears the completion bit, and writing 0 there leaves it set. Offset 9 always reads 0x00. Accepting a doorbell clears the status byte to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Window write strobe |
| host_rd | input | 1 | Window read strobe |
| host_addr | input | 4 | Window byte offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |

## Verification
The assertions take for granted that the host never asserts `host_wr` and `host_rd` in the same cycle. They also assume the host keeps `host_addr` within the ten window offsets. The bench drives every access through single-purpose write and read tasks that raise exactly one strobe for exactly one cycle, using offsets 0 to 9 only. The bench runs a small configuration (64 virtual registers, latency 5), which allows the register file to be swept completely. That size also puts the out-of-range boundary within easy reach.

// File: rtl/vmb_pkg.sv
package vmb_pkg;
  localparam logic [7:0] ACC_READ  = 8'h02;
  localparam logic [7:0] ACC_WRITE = 8'h03;
  localparam logic [7:0] ST_OK     = 8'h01;
  localparam logic [7:0] ST_FAIL   = 8'hFF;
  localparam logic [7:0] RING_VAL  = 8'h01;
  localparam logic [7:0] REGION_HI = 8'h80;

  localparam logic [3:0] OFF_RING   = 4'd0;
  localparam logic [3:0] OFF_STAT   = 4'd1;
  localparam logic [3:0] OFF_PTR_LO = 4'd2;
  localparam logic [3:0] OFF_PTR_HI = 4'd3;
  localparam logic [3:0] OFF_IRQ    = 4'd8;

  localparam int LOC_TYPE    = 0;
  localparam int LOC_COUNT   = 1;
  localparam int LOC_DATA    = 4;
  localparam int LOC_ADDR_LO = 6;
  localparam int LOC_ADDR_HI = 7;

  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_ACCESS, SQ_FINISH} seq_state_t;

  typedef struct packed {
    logic [7:0]  kind;
    logic [7:0]  count;
    logic [7:0]  data;
    logic [15:0] vaddr;
  } vmb_req_t;
endpackage

// File: rtl/vmb_vregs.sv
module vmb_vregs #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/vmb_seq.sv
module vmb_seq import vmb_pkg::*; #(
  parameter int LATENCY    = 8,
  parameter int VREG_DEPTH = 2048,
  localparam int AW    = $clog2(VREG_DEPTH),
  localparam int CNT_W = $clog2(LATENCY)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  vmb_req_t      req,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  input  logic [7:0]    ram_rdata,
  output logic          done,
  output logic [7:0]    done_status,
  output logic          done_load,
  output logic [7:0]    done_result
);
  localparam logic [15:0] VLIM = 16'(VREG_DEPTH);

  seq_state_t       state;
  vmb_req_t         req_q;
  logic [CNT_W-1:0] cnt;
  logic             valid, inrange;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      req_q <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (go) begin
          req_q <= req;
          cnt   <= CNT_W'(LATENCY - 3);
          state <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (cnt == '0) state <= SQ_ACCESS;
          else cnt <= cnt - CNT_W'(1);
        end
        SQ_ACCESS: state <= SQ_FINISH;
        default:   state <= SQ_IDLE;
      endcase
    end
  end

  assign valid       = ((req_q.kind == ACC_READ) || (req_q.kind == ACC_WRITE)) && (req_q.count == 8'h01);
  assign inrange     = req_q.vaddr < VLIM;
  assign ram_we      = (state == SQ_ACCESS) && valid && (req_q.kind == ACC_WRITE) && inrange;
  assign ram_addr    = req_q.vaddr[AW-1:0];
  assign ram_wdata   = req_q.data;
  assign done        = (state == SQ_FINISH);
  assign done_status = valid ? ST_OK : ST_FAIL;
  assign done_load   = valid && (req_q.kind == ACC_READ);
  assign done_result = inrange ? ram_rdata : 8'h00;

  // checker counter: cycles since the doorbell
  logic [15:0] since_q;
  always_ff @(posedge clk) begin
    if (rst) since_q <= '0;
    else if (go) since_q <= 16'd1;
    else if (state != SQ_IDLE) since_q <= since_q + 16'd1;
  end

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> since_q == 16'(LATENCY));
  // R3
  go_idle_chk: assert property (@(posedge clk) disable iff (rst)
    go |-> state == SQ_IDLE);
endmodule

// File: rtl/vmb_window.sv
module vmb_window import vmb_pkg::*; #(
  parameter int MBOX_BYTES = 8,
  localparam int IDX_W = $clog2(MBOX_BYTES)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [3:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       go,
  output vmb_req_t   req,
  input  logic       done,
  input  logic [7:0] done_status,
  input  logic       done_load,
  input  logic [7:0] done_result
);
  localparam logic [8:0] SLOT_LIM = 9'(MBOX_BYTES);

  logic [7:0]       ptr_lo, ptr_hi, stat_q;
  logic             db_q, irq_q;
  logic [7:0]       mbox [MBOX_BYTES];
  logic [8:0]       slot;
  logic             slot_ok;
  logic [IDX_W-1:0] idx;
  logic [7:0]       rd_mux;

  assign slot    = {1'b0, ptr_lo} + {7'b0, host_addr[1:0]};
  assign slot_ok = (host_addr[3:2] == 2'b01) && (ptr_hi == REGION_HI) && (slot < SLOT_LIM);
  assign idx     = slot[IDX_W-1:0];
  assign go      = host_wr && (host_addr == OFF_RING) && (host_wdata == RING_VAL) && !db_q;

  assign req.kind  = mbox[LOC_TYPE];
  assign req.count = mbox[LOC_COUNT];
  assign req.data  = mbox[LOC_DATA];
  assign req.vaddr = {mbox[LOC_ADDR_HI], mbox[LOC_ADDR_LO]};

  always_comb begin
    case (host_addr)
      OFF_RING:   rd_mux = {7'b0, db_q};
      OFF_STAT:   rd_mux = stat_q;
      OFF_PTR_LO: rd_mux = ptr_lo;
      OFF_PTR_HI: rd_mux = ptr_hi;
      OFF_IRQ:    rd_mux = {7'b0, irq_q};
      default:    rd_mux = slot_ok ? mbox[idx] : 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_lo     <= '0;
      ptr_hi     <= '0;
      stat_q     <= '0;
      db_q       <= 1'b0;
      irq_q      <= 1'b0;
      host_rdata <= '0;
      for (int i = 0; i < MBOX_BYTES; i++) mbox[i] <= 8'h00;
    end else begin
      if (host_wr) begin
        case (host_addr)
          OFF_RING:   if (go) begin db_q <= 1'b1; stat_q <= 8'h00; end
          OFF_PTR_LO: ptr_lo <= host_wdata;
          OFF_PTR_HI: ptr_hi <= host_wdata;
          OFF_IRQ:    if (host_wdata[0]) irq_q <= 1'b0;
          default:    if (slot_ok) mbox[idx] <= host_wdata;
        endcase
      end
      if (done) begin
        db_q   <= 1'b0;
        stat_q <= done_status;
        irq_q  <= 1'b1;
        if (done_load) mbox[LOC_DATA] <= done_result;
      end
      if (host_rd) host_rdata <= rd_mux;
    end
  end

  // R3
  doorbell_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (db_q && !done) |=> db_q);
  // R9
  status_code_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> (stat_q == ST_OK || stat_q == ST_FAIL));
  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !(host_wr && host_addr == OFF_IRQ && host_wdata[0])) |=> irq_q);
  // R1
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(host_wr && host_rd));
endmodule

// File: rtl/vreg_mailbox.sv
module vreg_mailbox import vmb_pkg::*; #(
  parameter int LATENCY    = 8,
  parameter int VREG_DEPTH = 2048,
  parameter int MBOX_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [3:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);
  localparam int AW = $clog2(VREG_DEPTH);

  logic          go, done, done_load, ram_we;
  vmb_req_t      req;
  logic [7:0]    done_status, done_result, ram_wdata, ram_rdata;
  logic [AW-1:0] ram_addr;

  vmb_window #(.MBOX_BYTES(MBOX_BYTES)) u_win (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .go(go), .req(req), .done(done), .done_status(done_status),
    .done_load(done_load), .done_result(done_result));

  vmb_seq #(.LATENCY(LATENCY), .VREG_DEPTH(VREG_DEPTH)) u_seq (
    .clk(clk), .rst(rst), .go(go), .req(req), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .done(done), .done_status(done_status), .done_load(done_load),
    .done_result(done_result));

  vmb_vregs #(.DEPTH(VREG_DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_rdata));
endmodule

// File: tb/sim_vreg_mailbox.sv
`timescale 1ns/1ps
module sim_vreg_mailbox;
  localparam int LAT   = 5;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;

  int checks = 0;
  int errors = 0;

  vreg_mailbox #(.LATENCY(LAT), .VREG_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata));

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic hw(input logic [3:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [3:0] a, output logic [7:0] d);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic build(input logic [7:0] kind, input logic [7:0] cnt,
                       input logic [15:0] va, input logic [7:0] d);
    hw(4'd2, 8'h00); hw(4'd3, 8'h80);
    hw(4'd4, kind);  hw(4'd5, cnt);
    hw(4'd2, 8'h04); hw(4'd4, d);
    hw(4'd6, va[7:0]); hw(4'd7, va[15:8]);
    hw(4'd8, 8'h01);
  endtask

  task automatic poll(output int n);
    logic [7:0] v;
    n = 0;
    do begin hr(4'd8, v); n++; end while (!v[0] && n < 200);
  endtask

  task automatic op(input logic [7:0] kind, input logic [7:0] cnt,
                    input logic [15:0] va, input logic [7:0] d,
                    output logic [7:0] st, output logic [7:0] res);
    int n;
    build(kind, cnt, va, d);
    hw(4'd0, 8'h01);
    poll(n);
    hr(4'd1, st);
    hr(4'd4, res);
    hw(4'd8, 8'h01);
  endtask

  initial begin
    repeat (20 * 150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, st, res;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    for (int o = 0; o < 10; o++) begin hr(4'(o), v); check("R1 reset read", v, 0); end

    // R2 pointer and mailbox positioning
    hw(4'd2, 8'h12); hw(4'd3, 8'h34);
    hr(4'd2, v); check("R2 ptr lo", v, 8'h12);
    hr(4'd3, v); check("R2 ptr hi", v, 8'h34);
    hw(4'd4, 8'hAA); hr(4'd4, v); check("R2 wrong region read", v, 0);
    hw(4'd2, 8'h00); hw(4'd3, 8'h80);
    hr(4'd4, v); check("R2 wrong region write dropped", v, 0);
    for (int i = 0; i < 4; i++) hw(4'(4 + i), 8'(8'h10 + i));
    hw(4'd2, 8'h04);
    for (int i = 0; i < 4; i++) hw(4'(4 + i), 8'(8'h20 + i));
    hw(4'd2, 8'h02);
    for (int i = 0; i < 4; i++) begin
      hr(4'(4 + i), v);
      check("R2 positioned read", v, (i < 2) ? 8'h12 + i : 8'h20 + i - 2);
    end
    hw(4'd2, 8'h06);
    hw(4'd6, 8'h77); hr(4'd6, v); check("R2 beyond mailbox", v, 0);
    hr(4'd4, v); check("R2 loc6", v, 8'h22);
    hr(4'd5, v); check("R2 loc7", v, 8'h23);

    // R5 exact latency, R3 doorbell clears on completion
    build(8'h03, 8'h01, 16'd5, 8'h3C);
    hw(4'd0, 8'h01);
    poll(n); check("R5 completion latency", n, LAT + 1);
    hr(4'd0, v); check("R3 doorbell idle after", v, 0);
    hr(4'd1, v); check("R6 write status", v, 8'h01);
    hw(4'd8, 8'h01);
    // R3 busy readback, R10 status cleared at doorbell
    build(8'h02, 8'h01, 16'd5, 8'h00);
    hw(4'd0, 8'h01);
    hr(4'd0, v); check("R3 doorbell busy", v, 1);
    hr(4'd1, v); check("R10 status cleared", v, 0);
    poll(n);
    hr(4'd4, v); check("R7 read back", v, 8'h3C);
    hw(4'd8, 8'h01);

    // R6 R7 full sweep
    for (int a = 0; a < DEPTH; a++) begin
      op(8'h03, 8'h01, 16'(a), pat(a), st, res);
      check("R6 sweep write status", st, 8'h01);
    end
    for (int a = 0; a < DEPTH; a++) begin
      op(8'h02, 8'h01, 16'(a), 8'h00, st, res);
      check("R7 sweep read status", st, 8'h01);
      check("R7 sweep read data", res, pat(a));
    end

    // R8 out of range
    op(8'h03, 8'h01, 16'(DEPTH), 8'h5A, st, res); check("R8 oob write status", st, 8'h01);
    op(8'h02, 8'h01, 16'd0, 8'h00, st, res); check("R8 alias untouched", res, pat(0));
    op(8'h02, 8'h01, 16'(DEPTH), 8'h77, st, res);
    check("R8 oob read status", st, 8'h01); check("R8 oob read zero", res, 0);
    op(8'h02, 8'h01, 16'hFFFF, 8'h77, st, res); check("R8 top read zero", res, 0);

    // R9 errors
    op(8'h07, 8'h01, 16'd3, 8'hEE, st, res);
    check("R9 bad type status", st, 8'hFF); check("R9 bad type loc4", res, 8'hEE);
    op(8'h03, 8'h02, 16'd3, 8'hEE, st, res); check("R9 bad count status", st, 8'hFF);
    op(8'h02, 8'h00, 16'd3, 8'h99, st, res);
    check("R9 read bad count status", st, 8'hFF); check("R9 read bad count loc4", res, 8'h99);
    op(8'h02, 8'h01, 16'd3, 8'h00, st, res); check("R9 file unchanged", res, pat(3));

    // R3 ignored doorbells
    hw(4'd0, 8'h02); hr(4'd0, v); check("R3 wrong ring value", v, 0);
    repeat (LAT + 2) @(negedge clk);
    hr(4'd8, v); check("R3 no completion", v, 0);
    build(8'h03, 8'h01, 16'd7, 8'h55);
    hw(4'd0, 8'h01); hw(4'd0, 8'h01);
    poll(n); hw(4'd8, 8'h01);
    repeat (LAT + 3) @(negedge clk);
    hr(4'd8, v); check("R3 busy ring ignored", v, 0);

    // R4 request latched at doorbell
    build(8'h03, 8'h01, 16'd9, 8'h66);
    hw(4'd0, 8'h01);
    hw(4'd4, 8'h11); hw(4'd6, 8'd10);
    poll(n); hw(4'd8, 8'h01);
    op(8'h02, 8'h01, 16'd9, 8'h00, st, res); check("R4 latched data", res, 8'h66);
    op(8'h02, 8'h01, 16'd10, 8'h00, st, res); check("R4 other addr untouched", res, pat(10));

    // R10 write-one-to-clear
    build(8'h02, 8'h01, 16'd1, 8'h00);
    hw(4'd0, 8'h01); poll(n);
    hw(4'd8, 8'h00); hr(4'd8, v); check("R10 write zero keeps", v, 1);
    hw(4'd8, 8'hFE); hr(4'd8, v); check("R10 bit0 clear keeps", v, 1);
    hw(4'd8, 8'h01); hr(4'd8, v); check("R10 clear", v, 0);
    hr(4'd9, v); check("R10 offset9", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule